// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a bank of asynchronous input lines (nineteen by default) and turns edges on them into interrupt and event requests. For each line, software chooses whether a rising edge, a falling edge or both count as a trigger. A detected trigger sets that line's pending bit, and the bit stays set until software clears it. Each line has an interrupt enable that gates its pending bit onto a level interrupt output. It also has an event enable, which passes a single-cycle event pulse at the moment the bit is set.

Edges are captured by flops clocked by the input lines themselves. This means a pulse narrower than one bus clock period is still caught. The captured edge crosses into the bus clock domain through a two-flop synchronizer before it reaches the pending logic.

Software reaches the block through a plain single-cycle register port: a write strobe, an address and write data, plus combinational read data. There is no stream traffic and no back-pressure. Every write is accepted in the cycle its strobe is high. A software trigger register can raise any pending bit as if an edge had occurred.

Top module: `exti_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `irq_o` and `evt_o` are all 0.
- R2: With bit i set in the rising-select register (address 2), a rising edge on line i sets pending bit i. The bit is first visible at the third rising clock edge after the line edge and not at the second. With the bit clear, a rising edge sets nothing.
- R3: With bit i set in the falling-select register (address 3), a falling edge on line i sets pending bit i with the same latency. With both select bits set, either edge sets it. With neither set, no edge sets it.
- R4: A high pulse of 1 ns (shorter than the 4 ns clock period) is caught on a line with rising select. A low pulse of 1 ns is caught on a line with only falling select.
- R5: Writing 1 to bit i of the pending register (address 5) clears pending bit i. Writing 0 leaves a bit unchanged, and no pending bit clears in any other way.
- R6: When a trigger for line i lands in the same cycle as a clear of pending bit i, the bit stays set.
- R7: Writing 1 to bit i of the software trigger register (address 4) sets pending bit i at that write's clock edge, whatever the select bits are. Address 4 reads as 0.
- R8: The pending bit is set even when the line's interrupt enable is 0. `irq_o[i]` is high exactly when pending bit i is set and bit i of the interrupt enable register (address 0, 1 = enabled) is set.
- R9: `evt_o[i]` is a single-cycle pulse in the cycle after a trigger sets pending bit i, only when bit i of the event enable register (address 1) is set.
- R10: Addresses 0 to 3 read back the written low NUM_LINES bits, with the upper bits of the data word reading 0. Line i maps to bit i in every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | NUM_LINES | Asynchronous input lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | NUM_LINES | Per-line level interrupt requests |
| evt_o | output | NUM_LINES | Per-line one-cycle event pulses |

## Verification
A wrong pending state shows on the ports at once. It appears at the pending read address, and on `irq_o` for an enabled line, from the cycle it goes wrong. An error in the capture or synchronizer path shows as a pending bit that appears one cycle early, one cycle late or not at all. The bench therefore checks the exact third-edge latency and the absence of set bits on every other line. A lost clear-versus-trigger ordering shows in the very next read of the pending register.

// File: rtl/exti_pkg.sv
package exti_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_IMASK  = 3'd0,
    REG_EMASK  = 3'd1,
    REG_RISE   = 3'd2,
    REG_FALL   = 3'd3,
    REG_SWTRIG = 3'd4,
    REG_PEND   = 3'd5
  } exti_reg_e;
endpackage

// File: rtl/exti_edge_capture.sv
// Per-line asynchronous edge capture: a toggle flop clocked by each edge of
// the line, then a synchronizer and a change detector in the bus domain.
module exti_edge_capture #(
  parameter int N           = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  output logic [N-1:0] hit_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic            rise_tog;
    logic            fall_tog;
    logic [SH_W-1:0] rise_sh;
    logic [SH_W-1:0] fall_sh;
    logic            rise_chg;
    logic            fall_chg;

    always_ff @(posedge line_i[g] or negedge rst_n) begin
      if (!rst_n) rise_tog <= 1'b0;
      else        rise_tog <= ~rise_tog;
    end

    always_ff @(negedge line_i[g] or negedge rst_n) begin
      if (!rst_n) fall_tog <= 1'b0;
      else        fall_tog <= ~fall_tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_sh <= '0;
        fall_sh <= '0;
      end else begin
        rise_sh <= {rise_sh[SH_W-2:0], rise_tog};
        fall_sh <= {fall_sh[SH_W-2:0], fall_tog};
      end
    end

    assign rise_chg = rise_sh[SH_W-1] ^ rise_sh[SH_W-2];
    assign fall_chg = fall_sh[SH_W-1] ^ fall_sh[SH_W-2];
    assign hit_o[g] = (rise_chg & rise_en_i[g]) | (fall_chg & fall_en_i[g]);
  end
endmodule

// File: rtl/exti_regs.sv
module exti_regs
  import exti_pkg::*;
#(
  parameter int N      = 19,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [N-1:0]          pend_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [N-1:0]          imask_o,
  output logic [N-1:0]          emask_o,
  output logic [N-1:0]          rise_o,
  output logic [N-1:0]          fall_o,
  output logic [N-1:0]          sw_set_o,
  output logic [N-1:0]          clr_o
);
  logic [N-1:0] wfield;
  assign wfield = wdata_i[N-1:0];

  if (DATA_W > N) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^wdata_i[DATA_W-1:N];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_o <= '0;
      emask_o <= '0;
      rise_o  <= '0;
      fall_o  <= '0;
    end else if (wr_i) begin
      case (addr_i)
        REG_IMASK: imask_o <= wfield;
        REG_EMASK: emask_o <= wfield;
        REG_RISE:  rise_o  <= wfield;
        REG_FALL:  fall_o  <= wfield;
        default: ;
      endcase
    end
  end

  assign sw_set_o = (wr_i && addr_i == REG_SWTRIG) ? wfield : '0;
  assign clr_o    = (wr_i && addr_i == REG_PEND)   ? wfield : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_IMASK: rdata_o[N-1:0] = imask_o;
      REG_EMASK: rdata_o[N-1:0] = emask_o;
      REG_RISE:  rdata_o[N-1:0] = rise_o;
      REG_FALL:  rdata_o[N-1:0] = fall_o;
      REG_PEND:  rdata_o[N-1:0] = pend_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/exti_pending.sv
module exti_pending #(
  parameter int N = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] sw_set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] imask_i,
  input  logic [N-1:0] emask_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] irq_o,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] set_now;
  assign set_now = hit_i | sw_set_i;

  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= '0;
      evt_o  <= '0;
    end else begin
      pend_o <= (pend_o & ~clr_i) | set_now;
      evt_o  <= set_now & emask_i;
    end
  end

  assign irq_o = pend_o & imask_i;
endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
  import exti_pkg::*;
#(
  parameter int NUM_LINES   = 19,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  line_i,
  input  logic                  reg_wr_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NUM_LINES-1:0]  irq_o,
  output logic [NUM_LINES-1:0]  evt_o
);
  logic [NUM_LINES-1:0] imask_w, emask_w, rise_w, fall_w;
  logic [NUM_LINES-1:0] sw_w, clr_w, hit_w, pend_w;

  exti_edge_capture #(.N(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (line_i),
    .rise_en_i (rise_w),
    .fall_en_i (fall_w),
    .hit_o     (hit_w)
  );

  exti_regs #(.N(NUM_LINES), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .pend_i   (pend_w),
    .rdata_o  (reg_rdata_o),
    .imask_o  (imask_w),
    .emask_o  (emask_w),
    .rise_o   (rise_w),
    .fall_o   (fall_w),
    .sw_set_o (sw_w),
    .clr_o    (clr_w)
  );

  exti_pending #(.N(NUM_LINES)) u_pending (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit_w),
    .sw_set_i (sw_w),
    .clr_i    (clr_w),
    .imask_i  (imask_w),
    .emask_i  (emask_w),
    .pend_o   (pend_w),
    .irq_o    (irq_o),
    .evt_o    (evt_o)
  );
endmodule

// File: rtl/exti_ctrl_chk.sv
module exti_ctrl_chk #(
  parameter int N      = 19,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_i,
  input logic [2:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [N-1:0]      irq_o,
  input logic [N-1:0]      evt_o,
  input logic [N-1:0]      pend_q,
  input logic [N-1:0]      emask_q,
  input logic [N-1:0]      hit_q,
  input logic [N-1:0]      sw_q
);
  logic [N-1:0] clr_req;
  logic         unused_chk;
  assign clr_req    = (reg_wr_i && reg_addr_i == 3'd5) ? reg_wdata_i[N-1:0] : '0;
  assign unused_chk = ^reg_wdata_i;

  // R5: a cleared bit with no trigger in that cycle is 0 afterwards
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_req) & ~$past(hit_q | sw_q)) == '0));

  // R5: a pending bit drops only where a clear was written
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_req)) == '0));

  // R8: an interrupt never shows without its pending bit
  assert_irq_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~pend_q) == '0));

  // R9: events appear only on lines whose event enable was set
  assert_evt_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_o & ~$past(emask_q)) == '0));

  // R9: an event pulse coincides with a set pending bit
  assert_evt_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_o & ~pend_q) == '0));
endmodule

bind exti_ctrl exti_ctrl_chk #(.N(NUM_LINES), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .evt_o       (evt_o),
  .pend_q      (pend_w),
  .emask_q     (emask_w),
  .hit_q       (hit_w),
  .sw_q        (sw_w)
);

// File: tb/exti_ctrl_tb.sv
`timescale 1ns/100ps
module exti_ctrl_tb;
  localparam int N  = 19;
  localparam int DW = 32;
  localparam logic [N-1:0] ALL = {N{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  lines = '0;
  logic          wr = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  irq, evt;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exti_ctrl #(.NUM_LINES(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(lines), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .evt_o(evt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [DW-1:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  // Drive line i to level, then check latency and result on all lines.
  task automatic step_chk(input int i, input logic lvl, input logic exp_b, input string tag);
    logic [DW-1:0] d;
    logic [N-1:0]  e;
    e = exp_b ? (N'(1) << i) : '0;
    @(negedge clk); #0.5 lines[i] = lvl;
    @(negedge clk);
    @(negedge clk);
    rreg(3'd5, d); chk({tag, " early"}, d, 32'h0);
    @(negedge clk);
    rreg(3'd5, d); chk({tag, " pend"}, d, 32'(e));
    chk({tag, " irq"}, 32'(irq), 32'(e));
    chk({tag, " evt"}, 32'(evt), 32'(e));
    @(negedge clk);
    chk({tag, " evt one-cycle R9"}, 32'(evt), 32'h0);
    wreg(3'd5, DW'(ALL));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements) act=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rreg(3'(a), d); chk($sformatf("R1 reg %0d", a), d, 32'h0);
    end
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 evt", 32'(evt), 32'h0);

    // R10 readback of config registers
    for (int a = 0; a < 4; a++) begin
      wreg(3'(a), 32'hFFFF_FFFF);
      rreg(3'(a), d); chk($sformatf("R10 ones %0d", a), d, 32'h0007_FFFF);
      wreg(3'(a), 32'hA5A5_5A5A);
      rreg(3'(a), d); chk($sformatf("R10 pattern %0d", a), d, 32'h0005_5A5A);
    end

    // R2/R3 sweep: every line, every trigger mode, both edge directions
    wreg(3'd0, DW'(ALL));
    wreg(3'd1, DW'(ALL));
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 4; m++) begin
        wreg(3'd2, m[0] ? DW'(N'(1) << i) : '0);
        wreg(3'd3, m[1] ? DW'(N'(1) << i) : '0);
        step_chk(i, 1'b1, m[0], $sformatf("R2 line %0d mode %0d rise", i, m));
        step_chk(i, 1'b0, m[1], $sformatf("R3 line %0d mode %0d fall", i, m));
      end
    end

    // R4 narrow pulses
    wreg(3'd2, DW'(N'(1) << 5));
    wreg(3'd3, '0);
    @(negedge clk); #0.5 lines[5] = 1'b1; #1 lines[5] = 1'b0;
    repeat (3) @(negedge clk);
    rreg(3'd5, d); chk("R4 high pulse", d, 32'(N'(1) << 5));
    wreg(3'd5, DW'(ALL));
    wreg(3'd2, '0);
    wreg(3'd3, DW'(N'(1) << 6));
    @(negedge clk); #0.5 lines[6] = 1'b1;
    repeat (4) @(negedge clk);
    rreg(3'd5, d); chk("R4 rise ignored on fall-only", d, 32'h0);
    #0.5 lines[6] = 1'b0; #1 lines[6] = 1'b1;
    repeat (3) @(negedge clk);
    rreg(3'd5, d); chk("R4 low pulse", d, 32'(N'(1) << 6));
    wreg(3'd5, DW'(ALL));
    wreg(3'd3, '0);
    @(negedge clk); lines[6] = 1'b0;
    repeat (4) @(negedge clk);

    // R7 software trigger ignores select bits, reads as 0
    wreg(3'd4, DW'(N'(1) << 9));
    rreg(3'd5, d); chk("R7 sw pend", d, 32'(N'(1) << 9));
    chk("R7 sw evt", 32'(evt), 32'(N'(1) << 9));
    rreg(3'd4, d); chk("R7 read zero", d, 32'h0);

    // R5 write of 0 bits leaves pending alone
    wreg(3'd5, DW'(~(N'(1) << 9)));
    rreg(3'd5, d); chk("R5 zero write keeps", d, 32'(N'(1) << 9));
    wreg(3'd5, DW'(N'(1) << 9));
    rreg(3'd5, d); chk("R5 clear", d, 32'h0);

    // R6 trigger and clear in the same cycle
    wreg(3'd2, DW'(N'(1) << 3));
    wreg(3'd4, DW'(N'(1) << 3));
    @(negedge clk); #0.5 lines[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr = 1'b1; addr = 3'd5; wdata = DW'(N'(1) << 3);
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    rreg(3'd5, d); chk("R6 set wins", d, 32'(N'(1) << 3));
    wreg(3'd5, DW'(ALL));
    rreg(3'd5, d); chk("R6 later clear", d, 32'h0);
    wreg(3'd2, '0);
    @(negedge clk); lines[3] = 1'b0;
    repeat (4) @(negedge clk);

    // R8 masked line still pends; enabling raises irq
    wreg(3'd0, '0);
    wreg(3'd2, DW'(N'(1) << 10));
    @(negedge clk); #0.5 lines[10] = 1'b1;
    repeat (3) @(negedge clk);
    rreg(3'd5, d); chk("R8 masked pend", d, 32'(N'(1) << 10));
    chk("R8 masked irq", 32'(irq), 32'h0);
    wreg(3'd0, DW'(N'(1) << 10));
    chk("R8 unmasked irq", 32'(irq), 32'(N'(1) << 10));
    wreg(3'd5, DW'(ALL));
    chk("R8 irq after clear", 32'(irq), 32'h0);

    // R9 event disabled
    wreg(3'd1, '0);
    wreg(3'd4, DW'(N'(1) << 12));
    chk("R9 evt masked", 32'(evt), 32'h0);
    rreg(3'd5, d); chk("R9 pend still set", d, 32'(N'(1) << 12));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule